// File: doc/BRIEF.md
# Phase-Offset Display-Enable Line-Start Generator

This block models a horizontal video timing controller that shares the CPU's clock but powers up with an unknown phase lag of 0 to 3 cycles. The lag is never resynchronized. A free-running line counter, referenced to the CPU, runs over a 512-cycle line. The controller's own view of the line is that count minus the lag. The CPU can write a refresh-rate register and a resolution register. The controller samples the refresh-rate register at its line-start checkpoint. It samples the resolution register one cycle later. It raises display enable (DE) for the line only when both samples select the 50 Hz, low-resolution mode.

A memory fetch unit runs at a fixed CPU-referenced phase and does not see the lag. It looks at DE at a fixed cycle and, two cycles later, issues a one-cycle LOAD strobe. The time from DE rising to LOAD therefore falls into one of four lag classes. The block reports that class for each line, and marks it invalid when the line never opened. A bench or a system model sets the start-up phase through an input that is captured while reset is held. This lets all four start-up states be reproduced.

Top module: `de_line_start_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, de, load and lag_valid are 0. Reset sets the refresh-rate register to 50 Hz (value 1) and the resolution register to low resolution (00), and clears the line counter to 0. A line with no writes after reset therefore opens.
- R2: phase_ofs is captured while rst_n is low and is held until the next reset. The controller cycle equals the line cycle minus the offset, modulo 512, where the line cycle is the count of clock cycles since reset release, modulo 512.
- R3: The refresh-rate register (1 = 50 Hz, 0 = 60 Hz) is sampled at line cycle 56+ofs. The 2-bit resolution register (00 = low) is sampled at 57+ofs. de rises in line cycle 58+ofs only if the first sample is 1 and the second is 00; de is 0 in cycle 57+ofs.
- R4: Writes are taken only in even line cycles; a write strobe in an odd cycle leaves the register unchanged. A write taken in cycle c is seen by a sample in cycle c.
- R5: de falls in line cycle 376+ofs. When the start condition fails, de stays 0 for the whole line.
- R6: load is high for exactly one cycle, line cycle 64, and only if de was high at line cycle 62. It is 0 in cycles 63 and 65.
- R7: From line cycle 64, lag_valid reports whether load was issued. When it was, lag_class equals 64 minus the de rise cycle, which is 6, 5, 4 or 3 for offsets 0, 1, 2 and 3. Both values hold until the next line's cycle 64.
- R8: The latest writes that still open the line are: offset 0, rate at 56 and resolution at 56; offset 1, rate at 56 and resolution at 58; offset 2, both at 58; offset 3, rate at 58 and resolution at 60. A write two cycles later than the listed one keeps the line closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_ofs | input | 2 | Start-up phase lag, captured during reset |
| freq_wr | input | 1 | Write strobe for the refresh-rate register |
| freq_din | input | 1 | Refresh-rate value, 1 = 50 Hz |
| res_wr | input | 1 | Write strobe for the resolution register |
| res_din | input | 2 | Resolution value, 00 = low |
| de | output | 1 | Horizontal display enable |
| load | output | 1 | One-cycle fetch strobe |
| lag_valid | output | 1 | Line opened and lag_class is meaningful |
| lag_class | output | 3 | DE-to-LOAD lag in cycles |

## Verification
A wrong captured offset or a wrong controller cycle moves the de edges. The effect shows at the first rise, by cycle 61 of the first line, and lag_class shows it at cycle 64. A wrong register state or a wrong write gate shows up as a line that opens when it should not, or stays closed when it should open. The effect is visible at the same checkpoint in which the bad value is sampled, within one line. A fault in the fetch stage appears as a load in the wrong cycle, a missing load or a doubled load, and as a wrong lag_valid from cycle 64 onward. The boundary writes at the latest cycles for each offset pin the sample slots to within one cycle.

// File: rtl/lsg_pkg.sv
// Shared encodings for the line-start generator.
// Assumes: one refresh-rate bit and a two-bit resolution field.
package lsg_pkg;
    localparam logic       FREQ_50  = 1'b1;
    localparam logic       FREQ_60  = 1'b0;
    localparam logic [1:0] RES_LOW  = 2'b00;
endpackage

// File: rtl/lsg_phase_counter.sv
// Free-running CPU-referenced line counter and the controller's lagged view.
// Assumes: the offset is held on phase_ofs while reset is asserted.
module lsg_phase_counter #(
    parameter int LINE_LEN = 512,
    parameter int OFS_W    = 2,
    localparam int CW      = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] phase_ofs,
    output logic [CW-1:0]    cpu_cyc,
    output logic [CW-1:0]    glue_cyc
);
    logic [OFS_W-1:0] ofs_q;
    logic [CW-1:0]    ofs_ext;

    // Capture the start-up offset while reset is held; never resynchronized.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= phase_ofs;
    end

    // Advance the CPU-referenced line cycle, wrapping at the line length.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cpu_cyc <= '0;
        else if (cpu_cyc == CW'(LINE_LEN - 1))   cpu_cyc <= '0;
        else                                     cpu_cyc <= cpu_cyc + 1'b1;
    end

    // Controller cycle: CPU cycle minus the offset, modulo the line length.
    always_comb begin
        ofs_ext = CW'(ofs_q);
        if (cpu_cyc >= ofs_ext) glue_cyc = cpu_cyc - ofs_ext;
        else                    glue_cyc = cpu_cyc + CW'(LINE_LEN) - ofs_ext;
    end

    // R2: the counter wraps to zero after the last cycle of a line.
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cyc == CW'(LINE_LEN - 1)) |=> (cpu_cyc == '0));
endmodule

// File: rtl/lsg_ctrl_regs.sv
// Refresh-rate and resolution registers with a same-cycle read bypass.
// Assumes: writes are only legal in even CPU cycles; odd-cycle strobes are dropped.
module lsg_ctrl_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_odd,
    input  logic       freq_wr,
    input  logic       freq_din,
    input  logic       res_wr,
    input  logic [1:0] res_din,
    output logic       freq_eff,
    output logic [1:0] res_eff
);
    import lsg_pkg::*;

    logic       freq_q;
    logic [1:0] res_q;
    logic       freq_take;
    logic       res_take;

    // Gate the strobes to even cycles.
    always_comb begin
        freq_take = freq_wr && !cyc_odd;
        res_take  = res_wr  && !cyc_odd;
    end

    // Hold the refresh-rate setting.
    always_ff @(posedge clk) begin
        if (!rst_n)         freq_q <= FREQ_50;
        else if (freq_take) freq_q <= freq_din;
    end

    // Hold the resolution setting.
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= RES_LOW;
        else if (res_take) res_q <= res_din;
    end

    // A write in the sampling cycle is already visible to that sample.
    always_comb begin
        freq_eff = freq_take ? freq_din : freq_q;
        res_eff  = res_take  ? res_din  : res_q;
    end

    // R4: an odd-cycle strobe leaves each register unchanged.
    a_r4_odd_freq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr && cyc_odd) |=> $stable(freq_q));
    a_r4_odd_res_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && cyc_odd) |=> $stable(res_q));
endmodule

// File: rtl/lsg_de_ctrl.sv
// Line-start decision: staggered samples at the checkpoint, DE window to line end.
// Assumes: glue_cyc is the lagged controller cycle; cpu_cyc is the CPU reference.
module lsg_de_ctrl #(
    parameter int CW     = 9,
    parameter int CHK    = 56,
    parameter int DE_END = 376
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] glue_cyc,
    input  logic [CW-1:0] cpu_cyc,
    input  logic          freq_eff,
    input  logic [1:0]    res_eff,
    output logic          de,
    output logic [CW-1:0] rise_cyc
);
    import lsg_pkg::*;

    localparam logic [CW-1:0] FREQ_SLOT = CW'(CHK);
    localparam logic [CW-1:0] RES_SLOT  = CW'(CHK + 1);
    localparam logic [CW-1:0] OFF_SLOT  = CW'(DE_END - 1);

    logic freq_ok;

    // Take the refresh-rate sample at the checkpoint.
    always_ff @(posedge clk) begin
        if (!rst_n)                     freq_ok <= 1'b0;
        else if (glue_cyc == FREQ_SLOT) freq_ok <= (freq_eff == FREQ_50);
    end

    // Open DE after the resolution sample; close it at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de       <= 1'b0;
            rise_cyc <= '0;
        end else if (glue_cyc == RES_SLOT) begin
            if (freq_ok && (res_eff == RES_LOW)) begin
                de       <= 1'b1;
                rise_cyc <= cpu_cyc + 1'b1;
            end
        end else if (glue_cyc == OFF_SLOT) begin
            de <= 1'b0;
        end
    end

    // R3: DE only rises two cycles after the checkpoint, after a 50 Hz sample.
    a_r3_rise_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> ((glue_cyc == CW'(CHK + 2)) && $past(freq_ok)));
    // R5: DE only falls at the line-end cycle.
    a_r5_fall_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> (glue_cyc == CW'(DE_END)));
endmodule

// File: rtl/lsg_fetch_unit.sv
// Fixed-phase fetch unit: watches DE, pulses LOAD, reports the lag class.
// Assumes: it sees only CPU-referenced cycles; DE arrives with the controller's lag.
module lsg_fetch_unit #(
    parameter int CW      = 9,
    parameter int LW      = 3,
    parameter int DET_AT  = 62,
    parameter int LOAD_AT = 64,
    parameter int MIN_LAG = 3,
    parameter int MAX_LAG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cpu_cyc,
    input  logic          de,
    input  logic [CW-1:0] rise_cyc,
    output logic          load,
    output logic          lag_valid,
    output logic [LW-1:0] lag_class
);
    localparam logic [CW-1:0] DET_C  = CW'(DET_AT);
    localparam logic [CW-1:0] PRE_C  = CW'(LOAD_AT - 1);
    localparam logic [CW-1:0] LOAD_C = CW'(LOAD_AT);

    logic          seen;
    logic [CW-1:0] lag_full;

    // Lag measured from the recorded DE rise to the LOAD cycle.
    always_comb lag_full = LOAD_C - rise_cyc;

    // Look at DE at the detect cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                seen <= 1'b0;
        else if (cpu_cyc == DET_C) seen <= de;
    end

    // Issue LOAD and update the lag report once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load      <= 1'b0;
            lag_valid <= 1'b0;
            lag_class <= '0;
        end else if (cpu_cyc == PRE_C) begin
            load      <= seen;
            lag_valid <= seen;
            lag_class <= seen ? LW'(lag_full) : '0;
        end else begin
            load      <= 1'b0;
        end
    end

    // R6: LOAD lands only in the fixed cycle and lasts one cycle.
    a_r6_load_slot: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cpu_cyc == LOAD_C));
    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    // R7: a valid lag class is one of the four possible classes.
    a_r7_lag_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        lag_valid |-> ((lag_class >= LW'(MIN_LAG)) && (lag_class <= LW'(MAX_LAG))));
endmodule

// File: rtl/de_line_start_gen.sv
// Top: line counter with start-up lag, control registers, DE decision, fetch unit.
// Assumes: phase_ofs is stable while rst_n is low.
module de_line_start_gen #(
    parameter int LINE_LEN = 512,
    parameter int OFS_W    = 2,
    parameter int CHK      = 56,
    parameter int DE_END   = 376,
    parameter int DET_AT   = 62,
    parameter int LOAD_AT  = 64,
    parameter int LW       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] phase_ofs,
    input  logic             freq_wr,
    input  logic             freq_din,
    input  logic             res_wr,
    input  logic [1:0]       res_din,
    output logic             de,
    output logic             load,
    output logic             lag_valid,
    output logic [LW-1:0]    lag_class
);
    localparam int CW      = $clog2(LINE_LEN);
    localparam int MAX_OFS = (1 << OFS_W) - 1;
    localparam int MAX_LAG = LOAD_AT - (CHK + 2);
    localparam int MIN_LAG = MAX_LAG - MAX_OFS;

    logic [CW-1:0] cpu_cyc;
    logic [CW-1:0] glue_cyc;
    logic [CW-1:0] rise_cyc;
    logic          freq_eff;
    logic [1:0]    res_eff;

    lsg_phase_counter #(.LINE_LEN(LINE_LEN), .OFS_W(OFS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .phase_ofs(phase_ofs),
        .cpu_cyc(cpu_cyc), .glue_cyc(glue_cyc)
    );

    lsg_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cyc_odd(cpu_cyc[0]),
        .freq_wr(freq_wr), .freq_din(freq_din),
        .res_wr(res_wr), .res_din(res_din),
        .freq_eff(freq_eff), .res_eff(res_eff)
    );

    lsg_de_ctrl #(.CW(CW), .CHK(CHK), .DE_END(DE_END)) u_de (
        .clk(clk), .rst_n(rst_n), .glue_cyc(glue_cyc), .cpu_cyc(cpu_cyc),
        .freq_eff(freq_eff), .res_eff(res_eff),
        .de(de), .rise_cyc(rise_cyc)
    );

    lsg_fetch_unit #(.CW(CW), .LW(LW), .DET_AT(DET_AT), .LOAD_AT(LOAD_AT),
                     .MIN_LAG(MIN_LAG), .MAX_LAG(MAX_LAG)) u_fetch (
        .clk(clk), .rst_n(rst_n), .cpu_cyc(cpu_cyc), .de(de), .rise_cyc(rise_cyc),
        .load(load), .lag_valid(lag_valid), .lag_class(lag_class)
    );

    // R1: nothing is asserted in the first cycle after reset release.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (!de && !load && !lag_valid));
endmodule

// File: tb/tb_de_line_start_gen.sv
module tb_de_line_start_gen;
    localparam int CLK_P = 10;
    localparam int LL    = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_ofs = 2'd0;
    logic       freq_wr = 1'b0;
    logic       freq_din = 1'b0;
    logic       res_wr = 1'b0;
    logic [1:0] res_din = 2'b00;
    logic       de, load, lag_valid;
    logic [2:0] lag_class;

    int checks = 0;
    int failures = 0;
    int bcyc = 0;
    int cur_ofs = 0;
    bit m_freq = 1'b1;
    logic [1:0] m_res = 2'b00;
    bit done = 1'b0;

    de_line_start_gen dut (
        .clk(clk), .rst_n(rst_n), .phase_ofs(phase_ofs),
        .freq_wr(freq_wr), .freq_din(freq_din), .res_wr(res_wr), .res_din(res_din),
        .de(de), .load(load), .lag_valid(lag_valid), .lag_class(lag_class)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (ofs=%0d)", req, act, exp, cur_ofs);
        end
    endtask

    function automatic int gcyc(int c, int o);
        return (c - o + LL) % LL;
    endfunction

    function automatic int latest_freq(int o);
        return (o < 2) ? 56 : 58;
    endfunction

    function automatic int latest_res(int o);
        return (o == 0) ? 56 : ((o == 3) ? 60 : 58);
    endfunction

    task automatic step();
        @(posedge clk);
        bcyc = (bcyc + 1) % LL;
        @(negedge clk);
    endtask

    task automatic do_reset(int o);
        @(negedge clk);
        rst_n = 1'b0;
        phase_ofs = 2'(o);
        cur_ofs = o;
        repeat (3) @(negedge clk);
        phase_ofs = 2'(3 - o);   // R2: changing the input after reset must have no effect
        rst_n = 1'b1;
        bcyc = 0;
        m_freq = 1'b1;
        m_res = 2'b00;
        check("R1 de after reset", int'(de), 0);
        check("R1 load after reset", int'(load), 0);
        check("R1 lag_valid after reset", int'(lag_valid), 0);
    endtask

    // One full line from cycle 0; writes at the given cycles (-1 = none).
    task automatic run_line(string tag, int fw, bit fv, int rw, logic [1:0] rv);
        bit fok = 1'b0;
        bit cond = 1'b0;
        int de_bad = 0;
        int ld_bad = 0;
        for (int c = 0; c < LL; c++) begin
            freq_wr  = (c == fw);
            freq_din = fv;
            res_wr   = (c == rw);
            res_din  = rv;
            if ((c == fw) && (c % 2 == 0)) m_freq = fv;
            if ((c == rw) && (c % 2 == 0)) m_res = rv;
            if (gcyc(c, cur_ofs) == 56) fok = m_freq;
            if (gcyc(c, cur_ofs) == 57) cond = fok && (m_res == 2'b00);
            if (int'(de) != int'(cond && gcyc(c, cur_ofs) >= 58 && gcyc(c, cur_ofs) < 376))
                de_bad++;
            if (int'(load) != int'(cond && c == 64)) ld_bad++;
            if (gcyc(c, cur_ofs) == 57) check({tag, " R3 de low before rise"}, int'(de), 0);
            if (gcyc(c, cur_ofs) == 58) check({tag, " R3 de at rise slot"}, int'(de), int'(cond));
            if (gcyc(c, cur_ofs) == 375) check({tag, " R5 de before fall"}, int'(de), int'(cond));
            if (gcyc(c, cur_ofs) == 376) check({tag, " R5 de at fall slot"}, int'(de), 0);
            if (c == 63) check({tag, " R6 load before slot"}, int'(load), 0);
            if (c == 64) check({tag, " R6 load at slot"}, int'(load), int'(cond));
            if (c == 65) check({tag, " R6 load after slot"}, int'(load), 0);
            if (c == 66) begin
                check({tag, " R7 lag_valid"}, int'(lag_valid), int'(cond));
                if (cond) check({tag, " R7 lag_class"}, int'(lag_class), 6 - cur_ofs);
            end
            step();
        end
        freq_wr = 1'b0;
        res_wr = 1'b0;
        check({tag, " R5 de whole-line mismatches"}, de_bad, 0);
        check({tag, " R6 load whole-line mismatches"}, ld_bad, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int o = 0; o < 4; o++) begin
            do_reset(o);
            run_line("R1 defaults", -1, 1'b0, -1, 2'b00);
            // R8: close both settings late in a line, then reopen at the latest cycles.
            run_line("R8 setup", 200, 1'b0, 200, 2'b01);
            run_line("R8 latest", latest_freq(o), 1'b1, latest_res(o), 2'b00);
            run_line("R8 setup", 200, 1'b0, 200, 2'b01);
            run_line("R8 rate late", latest_freq(o) + 2, 1'b1, latest_res(o), 2'b00);
            run_line("R8 setup", 200, 1'b0, 200, 2'b01);
            run_line("R8 res late", latest_freq(o), 1'b1, latest_res(o) + 2, 2'b00);
            // R4: odd-cycle writes are dropped, so the open settings survive.
            run_line("R4 odd write", 55, 1'b0, 53, 2'b10);
            run_line("R4 after odd", -1, 1'b0, -1, 2'b00);
            // R3: 60 Hz or a non-low resolution keeps the line closed.
            run_line("R3 60Hz", 40, 1'b0, -1, 2'b00);
            run_line("R3 hires", 40, 1'b1, 40, 2'b10);
            run_line("R3 reopen", 40, 1'b1, 40, 2'b00);
        end
        for (int k = 0; k < 40; k++) begin
            int fw, rw;
            if (k % 8 == 0) do_reset(int'($urandom_range(3, 0)));
            fw = ($urandom_range(3, 0) == 0) ? -1 : int'($urandom_range(66, 40));
            rw = ($urandom_range(3, 0) == 0) ? -1 : int'($urandom_range(66, 40));
            run_line("R3 random", fw, 1'($urandom_range(3, 0) != 0), rw,
                     ($urandom_range(2, 0) == 0) ? 2'($urandom_range(3, 1)) : 2'b00);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule